// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is an 8-bit up-counter that software can load and read. It has two count sources. In timer mode it advances on an internal instruction tick, which fires once every four system clocks. In counter mode it advances on edges of one of two external inputs. The external inputs pass through a two-stage synchronizer, and a control bit picks whether rising or falling transitions count. A divider can sit between the source and the counter, or the source can bypass it. When enabled, the divider passes one pulse for every 2^(select+1) source pulses. A software load also clears the divider.

A load stops counting for two instruction ticks. A small state machine with three states does this. It sits in `ST_RUN` while counting. Any write moves it to `ST_HOLD1`, and this write transition applies from every state. An instruction tick moves it from `ST_HOLD1` to `ST_HOLD2`, and a second tick moves it from `ST_HOLD2` back to `ST_RUN`. Increment requests that arrive outside `ST_RUN` are dropped.

When the count wraps from 0xFF to 0x00, two things happen. A sticky interrupt flag is set, and a one-clock overflow pulse is driven for a neighbouring timer.

Top module: `pretimer8`

## Requirements
- R1: After reset, `count` is 0x00, `irq_flag` is 0 and `ovf_pulse` is 0.
- R2: A write with `wr_en`=1 loads `wr_data` into `count`, and the loaded value is visible in the next cycle. The two instruction ticks after the write are discarded. With timer mode and bypass selected, the first increment lands 9 to 12 clocks after the write edge.
- R3: Timer mode (`cnt_mode`=0) with bypass (`pre_bypass`=1) advances `count` by one every 4 clocks.
- R4: With `pre_bypass`=0, the divider ratio is 2^(`pre_sel`+1), from 2 up to 256. In timer mode, increments are then 4×ratio clocks apart.
- R5: In counter mode (`cnt_mode`=1), `ext_sel`=0 counts `ext_pin` and `ext_sel`=1 counts `ext_alt`. Toggling the input that is not selected leaves `count` unchanged.
- R6: With `edge_fall`=0 only rising transitions of the selected input count. With `edge_fall`=1 only falling transitions count.
- R7: A wrap from 0xFF to 0x00 sets `irq_flag`. It also raises `ovf_pulse` for exactly the one cycle in which `count` first reads 0x00.
- R8: `irq_flag` stays at 1 until `flag_clr`=1. If a clear and a wrap fall in the same cycle, the flag ends at 1.
- R9: A write clears the divider's partial count. Source pulses seen before the write do not add to pulses seen after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load strobe for the count register |
| wr_data | input | 8 | Value to load |
| cnt_mode | input | 1 | 0 = instruction tick source, 1 = external edge source |
| ext_sel | input | 1 | 0 = `ext_pin`, 1 = `ext_alt` |
| edge_fall | input | 1 | 0 = rising edges count, 1 = falling edges count |
| pre_bypass | input | 1 | 1 = divider bypassed (1:1) |
| pre_sel | input | 3 | Divider ratio select |
| flag_clr | input | 1 | Clears the interrupt flag |
| ext_pin | input | 1 | External count input (asynchronous) |
| ext_alt | input | 1 | Alternate oscillator count input (asynchronous) |
| count | output | 8 | Current count value |
| irq_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-clock overflow pulse to a downstream timer |

## Verification
Timer mode is measured by the spacing of count changes, in clocks. This spacing separates the bypass path from each divider ratio, and it exposes the length of the post-write hold. Counter mode is driven with toggle trains that hold one more rise than fall. This separates the two polarities, and toggles on the unselected input show whether the source select works. A train split by a reload, with each half shorter than the divider ratio, shows whether the load clears the divider. Random configurations over source, polarity, ratio, start value and edge count are compared against a bench function. Wrap tests place a flag clear in the exact wrap cycle to check that the set has priority.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2
    } hold_state_t;
endpackage

// File: rtl/pt_edge_sync.sv
// Two-source synchronizer with polarity-selectable edge detect.
module pt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    input  logic sel_b,
    input  logic fall,
    output logic edge_pulse
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_a, sync_b;
    logic         cur, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= '0;
            sync_b <= '0;
            prev   <= 1'b0;
        end else begin
            sync_a <= {sync_a[MSB-1:0], in_a};
            sync_b <= {sync_b[MSB-1:0], in_b};
            prev   <= cur;
        end
    end

    always_comb begin
        cur        = sel_b ? sync_b[MSB] : sync_a[MSB];
        edge_pulse = fall ? (prev & ~cur) : (cur & ~prev);
    end
endmodule

// File: rtl/pt_prescaler.sv
// Power-of-two divider with bypass; partial count cleared on demand.
module pt_prescaler #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    input  logic             in_pulse,
    output logic             out_pulse
);
    logic [WIDTH:0]   ratio;
    logic [WIDTH-1:0] limit;
    logic [WIDTH-1:0] pcnt;
    logic             hit;

    always_comb begin
        ratio     = {{WIDTH{1'b0}}, 1'b1} << ({1'b0, sel} + 1'b1);
        limit     = ratio[WIDTH-1:0] - {{(WIDTH-1){1'b0}}, 1'b1};
        hit       = in_pulse && (pcnt >= limit);
        out_pulse = bypass ? in_pulse : hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (!bypass && in_pulse) begin
            pcnt <= hit ? '0 : pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/pt_count_core.sv
// Count register, write-hold state machine, overflow flag and pulse.
module pt_count_core
    import pt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             inc_pulse,
    input  logic             insn_tick,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] count,
    output logic             irq_flag,
    output logic             ovf_pulse
);
    hold_state_t state, state_nx;
    logic        inc_ok, wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (wr_en) begin
            state_nx = ST_HOLD1;
        end else begin
            unique case (state)
                ST_RUN:   state_nx = ST_RUN;
                ST_HOLD1: if (insn_tick) state_nx = ST_HOLD2;
                ST_HOLD2: if (insn_tick) state_nx = ST_RUN;
                default:  state_nx = ST_RUN;
            endcase
        end
    end

    always_comb begin
        inc_ok = inc_pulse && !wr_en && (state == ST_RUN);
        wrap   = inc_ok && (count == {WIDTH{1'b1}});
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            irq_flag  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            if (wr_en)       count <= wr_data;
            else if (inc_ok) count <= count + 1'b1;
            irq_flag  <= wrap | (irq_flag & ~flag_clr);
            ovf_pulse <= wrap;
        end
    end
endmodule

// File: rtl/pretimer8.sv
module pretimer8 #(
    parameter int WIDTH         = 8,
    parameter int SEL_W         = 3,
    parameter int CLKS_PER_INSN = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cnt_mode,
    input  logic             ext_sel,
    input  logic             edge_fall,
    input  logic             pre_bypass,
    input  logic [SEL_W-1:0] pre_sel,
    input  logic             flag_clr,
    input  logic             ext_pin,
    input  logic             ext_alt,
    output logic [WIDTH-1:0] count,
    output logic             irq_flag,
    output logic             ovf_pulse
);
    localparam int PH_W = (CLKS_PER_INSN > 1) ? $clog2(CLKS_PER_INSN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_INSN - 1);

    logic [PH_W-1:0] phase;
    logic            insn_tick, ext_edge, src_pulse, div_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          phase <= '0;
        else if (insn_tick)  phase <= '0;
        else                 phase <= phase + 1'b1;
    end

    always_comb begin
        insn_tick = (phase == PH_LAST);
        src_pulse = cnt_mode ? ext_edge : insn_tick;
    end

    pt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_a       (ext_pin),
        .in_b       (ext_alt),
        .sel_b      (ext_sel),
        .fall       (edge_fall),
        .edge_pulse (ext_edge)
    );

    pt_prescaler #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wr_en),
        .bypass    (pre_bypass),
        .sel       (pre_sel),
        .in_pulse  (src_pulse),
        .out_pulse (div_pulse)
    );

    pt_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .inc_pulse (div_pulse),
        .insn_tick (insn_tick),
        .flag_clr  (flag_clr),
        .count     (count),
        .irq_flag  (irq_flag),
        .ovf_pulse (ovf_pulse)
    );
endmodule

// File: rtl/pretimer8_chk.sv
module pretimer8_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             flag_clr,
    input logic [WIDTH-1:0] count,
    input logic             irq_flag,
    input logic             ovf_pulse
);
    // R2: loaded value visible next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));

    // R2: still no increment one cycle later
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en, 2) && !$past(wr_en)) |-> count == $past(wr_data, 2));

    // R3/R4: without a write the count moves by at most one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count) || count == $past(count) + {{(WIDTH-1){1'b0}}, 1'b1}));

    // R7: overflow pulse only on a zero count, with flag set
    a_r7_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0 && irq_flag));

    // R7: flag rises only with an overflow
    a_r7_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ovf_pulse);

    // R8: flag sticky without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
endmodule

bind pretimer8 pretimer8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flag_clr  (flag_clr),
    .count     (count),
    .irq_flag  (irq_flag),
    .ovf_pulse (ovf_pulse)
);

// File: tb/tb_pretimer8.sv
`timescale 1ns/1ps
module tb_pretimer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cnt_mode = 1'b0, ext_sel = 1'b0, edge_fall = 1'b0;
    logic       pre_bypass = 1'b1;
    logic [2:0] pre_sel = '0;
    logic       flag_clr = 1'b0, ext_pin = 1'b0, ext_alt = 1'b0;
    logic [7:0] count;
    logic       irq_flag, ovf_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pretimer8 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cnt_mode(cnt_mode), .ext_sel(ext_sel), .edge_fall(edge_fall),
        .pre_bypass(pre_bypass), .pre_sel(pre_sel), .flag_clr(flag_clr),
        .ext_pin(ext_pin), .ext_alt(ext_alt),
        .count(count), .irq_flag(irq_flag), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input bit byp, input int ps);
        return byp ? 1 : (2 << ps);
    endfunction

    // expected count after n toggles starting low
    function automatic logic [7:0] exp_count(input logic [7:0] start, input int n,
                                             input bit fall, input bit byp, input int ps);
        int edges;
        edges = fall ? n / 2 : (n + 1) / 2;
        return start + 8'(edges / ratio_of(byp, ps));
    endfunction

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_change(output int n);
        logic [7:0] old;
        old = count;
        n = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); n++;
            if (count != old) break;
        end
    endtask

    task automatic toggle_in(input bit alt, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (alt) ext_alt = ~ext_alt; else ext_pin = ~ext_pin;
            repeat (5) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic prep(input bit mode, input bit sel, input bit fall, input bit byp,
                        input int ps, input logic [7:0] start);
        @(negedge clk);
        ext_pin = 1'b0; ext_alt = 1'b0;
        cnt_mode = mode; ext_sel = sel; edge_fall = fall;
        pre_bypass = byp; pre_sel = 3'(ps);
        repeat (10) @(negedge clk);
        do_write(start);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n, rnd;
        logic [7:0] st;
        rnd = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(count == 8'h00, "R1 count", count, 0);
        chk(irq_flag == 1'b0, "R1 flag", irq_flag, 0);
        chk(ovf_pulse == 1'b0, "R1 ovf", ovf_pulse, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 load and hold, timer bypass
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h40;
        @(negedge clk); wr_en = 1'b0;
        chk(count == 8'h40, "R2 load", count, 8'h40);
        wait_change(n);
        chk(n >= 9 && n <= 12, "R2 hold length", n, 10);
        // R3 interval
        wait_change(n);
        chk(n == 4, "R3 interval", n, 4);
        wait_change(n);
        chk(n == 4, "R3 interval", n, 4);

        // R4 divider intervals in timer mode
        for (int k = 0; k < 4; k++) begin
            int ps;
            ps = (k == 0) ? 0 : int'($urandom_range(0, 5));
            prep(1'b0, 1'b0, 1'b0, 1'b0, ps, 8'h00);
            wait_change(n);
            wait_change(n);
            chk(n == 4 * ratio_of(1'b0, ps), "R4 divided interval", n, 4 * ratio_of(1'b0, ps));
        end

        // R7 / R8 overflow
        prep(1'b0, 1'b0, 1'b0, 1'b1, 0, 8'hFD);
        for (int i = 0; i < 5 && count != 8'h00; i++) wait_change(n);
        chk(count == 8'h00, "R7 wrapped", count, 0);
        chk(ovf_pulse == 1'b1, "R7 ovf pulse", ovf_pulse, 1);
        chk(irq_flag == 1'b1, "R7 flag set", irq_flag, 1);
        @(negedge clk);
        chk(ovf_pulse == 1'b0, "R7 ovf one cycle", ovf_pulse, 0);
        do_write(8'hFE);
        for (int i = 0; i < 3 && count != 8'hFF; i++) wait_change(n);
        chk(irq_flag == 1'b1, "R8 sticky", irq_flag, 1);
        repeat (2) @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(count == 8'h00, "R8 wrap cycle", count, 0);
        chk(irq_flag == 1'b1, "R8 set wins over clear", irq_flag, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(irq_flag == 1'b0, "R8 clear", irq_flag, 0);

        // R5 / R6 counter mode directed
        prep(1'b1, 1'b0, 1'b0, 1'b1, 0, 8'h20);
        toggle_in(1'b0, 5);
        chk(count == 8'h23, "R6 rising on pin", count, 8'h23);
        toggle_in(1'b1, 4);
        chk(count == 8'h23, "R5 unselected alt ignored", count, 8'h23);
        prep(1'b1, 1'b1, 1'b1, 1'b1, 0, 8'h80);
        toggle_in(1'b1, 5);
        chk(count == 8'h82, "R6 falling on alt", count, 8'h82);
        toggle_in(1'b0, 3);
        chk(count == 8'h82, "R5 unselected pin ignored", count, 8'h82);

        // R9 write clears divider (ratio 4)
        prep(1'b1, 1'b0, 1'b0, 1'b0, 1, 8'h10);
        toggle_in(1'b0, 6);
        chk(count == 8'h10, "R9 below ratio", count, 8'h10);
        do_write(8'h10);
        repeat (12) @(negedge clk);
        toggle_in(1'b0, 6);
        chk(count == 8'h10, "R9 divider cleared by write", count, 8'h10);
        toggle_in(1'b0, 2);
        chk(count == 8'h11, "R9 fourth edge counts", count, 8'h11);

        // R4/R5/R6 random counter-mode runs
        for (int k = 0; k < 10; k++) begin
            bit sel, fall, byp;
            int ps, nt;
            sel  = 1'($urandom_range(0, 1));
            fall = 1'($urandom_range(0, 1));
            byp  = 1'($urandom_range(0, 1));
            ps   = int'($urandom_range(0, 2));
            nt   = int'($urandom_range(0, 30));
            st   = 8'($urandom_range(0, 255));
            prep(1'b1, sel, fall, byp, ps, st);
            toggle_in(sel, nt);
            chk(count == exp_count(st, nt, fall, byp, ps), "R4/R5/R6 random",
                count, exp_count(st, nt, fall, byp, ps));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule